// File: doc/BRIEF.md
# Spare Allocation Order Sequencer

This block steps one shared repair analysis engine through every order in which a memory's spare rows and spare columns can be handed out. It holds a strategy word that is as wide as the total number of spares. Bit value 1 assigns a spare row at that step of the order and bit value 0 assigns a spare column. A short feedback shift register generates the strategy words one after another. Running one engine several times replaces a bank of engines that each evaluate a single order.

For each strategy the sequencer sends a one-cycle restart pulse to the memory self-test and then waits for the self-test to report completion along with the engine's verdict. The first strategy that the engine reports as repairable is frozen and published as the winning order. If every order fails, the sequencer reports completion with the repairable flag low. The spare counts are parameters, with one or two spares of each kind supported. They fix the word width, the seed word, the feedback taps and the number of orders tried, which equals the binomial count of (rows + columns) choose rows.

Top module: `alloc_order_seq`

## Requirements
- R1: After reset the strategy word equals the seed of the configuration, and the restart pulse, analysis-done flag, repairable flag and winning word are all zero.
- R2: A start request while idle or finished loads the seed and clears done, repairable and winning. The seeds are 10 for one row and one column, 100 for one row and two columns, 110 for two rows and one column, and 1001 for two rows and two columns. Bit value 1 means spare row and bit value 0 means spare column.
- R3: With two rows and two columns the strategies appear in the order 1001, 1010, 0101, 1100, 0110, 0011. In the other three configurations each next strategy is the previous one rotated right by one bit.
- R4: The restart output is high for exactly one cycle per strategy. It rises one cycle after the strategy word takes its new value, and the word does not change in the cycle the pulse is high.
- R5: The strategy advances only when self-test completion arrives with a not-repairable verdict while a strategy is under test. A completion that arrives while idle or finished has no effect on any output.
- R6: A completion with a repairable verdict freezes the strategy word, sets done and repairable in the next cycle, and copies the strategy to the winning output.
- R7: When the last strategy fails, done is set with repairable low and the winning output zero.
- R8: A start request while a strategy is under test is ignored. The strategy word holds and no restart is issued.
- R9: Every strategy word has exactly as many ones as there are spare rows.
- R10: A run tries exactly the binomial count of strategies when all of them fail (6 for two rows and two columns, 3 for two rows and one column), and stops after the first one that is repairable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a new allocation search |
| bist_done | input | 1 | Self-test run complete, verdict valid |
| engine_repairable | input | 1 | Engine verdict for the current strategy |
| strategy | output | N_ROW_SPARES+N_COL_SPARES | Current allocation order, 1 = row, 0 = column |
| bist_restart | output | 1 | One-cycle request to rerun the self-test |
| analysis_done | output | 1 | Search finished |
| final_repairable | output | 1 | Search found a repairable order |
| winning_strategy | output | N_ROW_SPARES+N_COL_SPARES | Order that repaired the memory, zero otherwise |

## Verification
A wrong tap mask or seed appears on the strategy port at the first restart after start, or at the strategy's first step, as a word out of sequence or with the wrong number of ones. A broken try counter ends a failing search one strategy early or one strategy late, which shows as a restart count that differs from the binomial count or as done rising at the wrong point. A controller that leaves its waiting state too early or too late shows up within one cycle of the completion input, as a missing restart, a doubled restart, or a result flag that does not change.

// File: rtl/alloc_order_pkg.sv
package alloc_order_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_KICK,
    SQ_WAIT,
    SQ_DONE
  } sq_state_e;

  localparam int MAX_W = 8;

  // number of distinct orders of rows among (rows + cols) slots
  function automatic int n_choose_k(input int n, input int k);
    int acc;
    acc = 1;
    for (int i = 1; i <= k; i++) begin
      acc = acc * (n - k + i) / i;
    end
    return acc;
  endfunction

  function automatic logic [MAX_W-1:0] seed_word(input int rows, input int cols);
    logic [MAX_W-1:0] w;
    int width;
    width = rows + cols;
    w = '0;
    if (rows == 2 && cols == 2) begin
      w = 8'b0000_1001;
    end else begin
      for (int i = 0; i < MAX_W; i++) begin
        if (i >= width - rows && i < width) w[i] = 1'b1;
      end
    end
    return w;
  endfunction

  // xor mask applied on a right shift when the dropped bit is 1
  function automatic logic [MAX_W-1:0] tap_mask(input int rows, input int cols);
    logic [MAX_W-1:0] w;
    int width;
    width = rows + cols;
    w = '0;
    if (rows == 2 && cols == 2) begin
      w = 8'b0000_1110;
    end else begin
      for (int i = 0; i < MAX_W; i++) begin
        if (i == width - 1) w[i] = 1'b1;
      end
    end
    return w;
  endfunction

endpackage

// File: rtl/order_lfsr.sv
module order_lfsr #(
  parameter int          ROWS = 2,
  parameter int          W    = 4,
  parameter logic [W-1:0] SEED = 4'b1001,
  parameter logic [W-1:0] TAPS = 4'b1110
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] word
);

  logic [W-1:0] word_d;
  logic         word_en;

  assign word_en = load | step;

  always_comb begin
    word_d = word;
    if (load) begin
      word_d = SEED;
    end else if (step) begin
      word_d = (word >> 1) ^ (word[0] ? TAPS : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= SEED;
    end else if (word_en) begin
      word <= word_d;
    end
  end

  // every order keeps the row count fixed
  assert_row_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(word) == ROWS);

endmodule

// File: rtl/try_counter.sv
module try_counter #(
  parameter int N = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);

  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(N - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en = clr | inc;
  assign last   = (cnt == LAST_IDX);

  always_comb begin
    cnt_d = cnt;
    if (clr) begin
      cnt_d = '0;
    end else if (inc) begin
      cnt_d = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_d;
    end
  end

  assert_try_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_IDX);

  assert_no_step_past_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |-> !last);

endmodule

// File: rtl/order_ctrl.sv
module order_ctrl
  import alloc_order_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         bist_done,
  input  logic         engine_ok,
  input  logic         last,
  input  logic [W-1:0] strategy,
  output logic         load,
  output logic         step,
  output logic         restart,
  output logic         done,
  output logic         rep,
  output logic [W-1:0] win
);

  sq_state_e    st_q, st_d;
  logic         restart_d, done_d, rep_d;
  logic [W-1:0] win_d;

  always_comb begin
    st_d      = st_q;
    load      = 1'b0;
    step      = 1'b0;
    restart_d = 1'b0;
    done_d    = done;
    rep_d     = rep;
    win_d     = win;
    unique case (st_q)
      SQ_IDLE, SQ_DONE: begin
        if (start) begin
          load   = 1'b1;
          done_d = 1'b0;
          rep_d  = 1'b0;
          win_d  = '0;
          st_d   = SQ_KICK;
        end
      end
      SQ_KICK: begin
        restart_d = 1'b1;
        st_d      = SQ_WAIT;
      end
      SQ_WAIT: begin
        if (bist_done) begin
          if (engine_ok) begin
            done_d = 1'b1;
            rep_d  = 1'b1;
            win_d  = strategy;
            st_d   = SQ_DONE;
          end else if (last) begin
            done_d = 1'b1;
            st_d   = SQ_DONE;
          end else begin
            step = 1'b1;
            st_d = SQ_KICK;
          end
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      restart <= 1'b0;
      done    <= 1'b0;
      rep     <= 1'b0;
      win     <= '0;
    end else begin
      st_q    <= st_d;
      restart <= restart_d;
      done    <= done_d;
      rep     <= rep_d;
      win     <= win_d;
    end
  end

  assert_restart_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !restart);

  assert_restart_word_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> $stable(strategy));

  assert_freeze_on_success_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rep && !start) |=> $stable(strategy));

  assert_fail_has_no_winner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rep) |-> (win == '0));

endmodule

// File: rtl/alloc_order_seq.sv
module alloc_order_seq
  import alloc_order_pkg::*;
#(
  parameter int N_ROW_SPARES = 2,
  parameter int N_COL_SPARES = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start,
  input  logic                                 bist_done,
  input  logic                                 engine_repairable,
  output logic [N_ROW_SPARES+N_COL_SPARES-1:0] strategy,
  output logic                                 bist_restart,
  output logic                                 analysis_done,
  output logic                                 final_repairable,
  output logic [N_ROW_SPARES+N_COL_SPARES-1:0] winning_strategy
);

  localparam int W      = N_ROW_SPARES + N_COL_SPARES;
  localparam int NSTRAT = n_choose_k(W, N_ROW_SPARES);
  localparam logic [MAX_W-1:0] SEED_FULL = seed_word(N_ROW_SPARES, N_COL_SPARES);
  localparam logic [MAX_W-1:0] TAPS_FULL = tap_mask(N_ROW_SPARES, N_COL_SPARES);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       load, step, last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  order_lfsr #(
    .ROWS (N_ROW_SPARES),
    .W    (W),
    .SEED (SEED_FULL[W-1:0]),
    .TAPS (TAPS_FULL[W-1:0])
  ) u_lfsr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (load),
    .step  (step),
    .word  (strategy)
  );

  try_counter #(
    .N (NSTRAT)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (load),
    .inc   (step),
    .last  (last)
  );

  order_ctrl #(
    .W (W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .bist_done (bist_done),
    .engine_ok (engine_repairable),
    .last      (last),
    .strategy  (strategy),
    .load      (load),
    .step      (step),
    .restart   (bist_restart),
    .done      (analysis_done),
    .rep       (final_repairable),
    .win       (winning_strategy)
  );

  // a word change without completion or start is an illegal advance
  assert_advance_needs_done_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!bist_done && !start) |=> $stable(strategy));

endmodule

// File: tb/tb_alloc_order_seq.sv
module tb_alloc_order_seq;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // 2 rows, 2 columns
  logic       start_a, done_a, ok_a;
  logic [3:0] strat_a, win_a;
  logic       rs_a, fin_a, rep_a;
  // 2 rows, 1 column
  logic       start_b, done_b, ok_b;
  logic [2:0] strat_b, win_b;
  logic       rs_b, fin_b, rep_b;

  alloc_order_seq #(.N_ROW_SPARES(2), .N_COL_SPARES(2)) dut (
    .clk(clk), .rst_n(rst_n), .start(start_a), .bist_done(done_a),
    .engine_repairable(ok_a), .strategy(strat_a), .bist_restart(rs_a),
    .analysis_done(fin_a), .final_repairable(rep_a), .winning_strategy(win_a)
  );

  alloc_order_seq #(.N_ROW_SPARES(2), .N_COL_SPARES(1)) dut_b (
    .clk(clk), .rst_n(rst_n), .start(start_b), .bist_done(done_b),
    .engine_repairable(ok_b), .strategy(strat_b), .bist_restart(rs_b),
    .analysis_done(fin_b), .final_repairable(rep_b), .winning_strategy(win_b)
  );

  int n_chk  = 0;
  int n_fail = 0;

  localparam logic [3:0] EXP_A [6] = '{4'b1001, 4'b1010, 4'b0101, 4'b1100, 4'b0110, 4'b0011};

  task automatic chk(input bit cond, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_restart_a(output bit seen);
    seen = 1'b0;
    for (int w = 0; w < 8 && !seen; w++) begin
      if (rs_a) seen = 1'b1;
      else @(negedge clk);
    end
  endtask

  // target = index of the repairable strategy, 6 = none
  task automatic run_case_a(input int target);
    bit seen, finished;
    int tries;
    @(negedge clk) start_a = 1'b1;
    @(negedge clk) start_a = 1'b0;
    chk(strat_a == 4'b1001, "R2 seed", strat_a, 4'b1001);
    chk(!fin_a && !rep_a && win_a == 0, "R2 results cleared", {fin_a, rep_a, win_a}, 0);
    chk(!rs_a, "R4 restart after load", rs_a, 0);
    finished = 1'b0;
    tries = 0;
    for (int i = 0; i < 6; i++) begin
      if (!finished) begin
        wait_restart_a(seen);
        chk(seen, "R4 restart issued", seen, 1);
        tries++;
        chk(strat_a == EXP_A[i], "R3 order", strat_a, EXP_A[i]);
        @(negedge clk);
        chk(!rs_a, "R4 pulse width", rs_a, 0);
        chk(strat_a == EXP_A[i], "R5 holds while waiting", strat_a, EXP_A[i]);
        if (i == 1) begin
          start_a = 1'b1;
          @(negedge clk) start_a = 1'b0;
          chk(strat_a == EXP_A[i] && !rs_a, "R8 start ignored", {rs_a, strat_a}, EXP_A[i]);
        end
        done_a = 1'b1;
        ok_a   = (i == target);
        @(negedge clk);
        done_a = 1'b0;
        ok_a   = 1'b0;
        if (i == target) begin
          chk(fin_a && rep_a, "R6 success flags", {fin_a, rep_a}, 2'b11);
          chk(win_a == EXP_A[i], "R6 winner", win_a, EXP_A[i]);
          chk(strat_a == EXP_A[i], "R6 frozen", strat_a, EXP_A[i]);
          finished = 1'b1;
        end else if (i == 5) begin
          chk(fin_a && !rep_a, "R7 unrepairable flags", {fin_a, rep_a}, 2'b10);
          chk(win_a == 0, "R7 no winner", win_a, 0);
          finished = 1'b1;
        end else begin
          chk(!fin_a && !rs_a, "R4 update precedes restart", {fin_a, rs_a}, 0);
          chk(strat_a == EXP_A[i+1], "R3 step", strat_a, EXP_A[i+1]);
        end
      end
    end
    chk(tries == ((target < 6) ? target + 1 : 6), "R10 tries", tries,
        (target < 6) ? target + 1 : 6);
    // completion while finished must change nothing
    begin
      logic [3:0] s0, w0;
      logic       r0;
      s0 = strat_a; w0 = win_a; r0 = rep_a;
      done_a = 1'b1; ok_a = ~r0;
      @(negedge clk);
      done_a = 1'b0; ok_a = 1'b0;
      @(negedge clk);
      chk(strat_a == s0 && win_a == w0 && rep_a == r0 && fin_a && !rs_a,
          "R5 done ignored when finished", {rs_a, rep_a, strat_a}, {1'b0, r0, s0});
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [2:0] eb;
    bit seen;
    rst_n = 1'b0;
    start_a = 1'b0; done_a = 1'b0; ok_a = 1'b0;
    start_b = 1'b0; done_b = 1'b0; ok_b = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk(strat_a == 4'b1001 && !rs_a && !fin_a && !rep_a && win_a == 0, "R1 reset 2R2C",
        {rs_a, fin_a, rep_a, win_a, strat_a}, 4'b1001);
    chk(strat_b == 3'b110 && !rs_b && !fin_b && !rep_b && win_b == 0, "R1 reset 2R1C",
        {rs_b, fin_b, rep_b, win_b, strat_b}, 3'b110);

    // completion while idle has no effect
    done_a = 1'b1; ok_a = 1'b1;
    @(negedge clk);
    done_a = 1'b0; ok_a = 1'b0;
    @(negedge clk);
    chk(!fin_a && !rep_a && !rs_a && strat_a == 4'b1001, "R5 done ignored when idle",
        {fin_a, rep_a, rs_a, strat_a}, 4'b1001);

    for (int t = 0; t <= 6; t++) run_case_a(t);

    // 2R1C: rotation order, all fail
    @(negedge clk) start_b = 1'b1;
    @(negedge clk) start_b = 1'b0;
    eb = 3'b110;
    chk(strat_b == eb, "R2 seed 2R1C", strat_b, eb);
    for (int i = 0; i < 3; i++) begin
      seen = 1'b0;
      for (int w = 0; w < 8 && !seen; w++) begin
        if (rs_b) seen = 1'b1;
        else @(negedge clk);
      end
      chk(seen, "R4 restart 2R1C", seen, 1);
      chk(strat_b == eb, "R3 rotation 2R1C", strat_b, eb);
      chk($countones(strat_b) == 2, "R9 row count", strat_b, eb);
      @(negedge clk);
      done_b = 1'b1;
      @(negedge clk);
      done_b = 1'b0;
      eb = {eb[0], eb[2:1]};
    end
    chk(fin_b && !rep_b && win_b == 0, "R7 2R1C unrepairable", {fin_b, rep_b, win_b}, 3'b100);
    chk(strat_b == 3'b101, "R10 stopped after three tries", strat_b, 3'b101);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule